// File: doc/BRIEF.md
# Row Column Write Mask Merger

This block forms the final four-lane quadword that is written back to vector memory for one output vector. Each cycle that a vector is presented, it takes the unpacked input lanes, the quadword currently held at the destination, four externally held column values and four internal row registers. It produces the lane values to store. A 2-bit mode can add the row registers to the input lanes, and in one mode it can also feed those sums back into the row registers. A running total therefore builds up across consecutive vectors.

When masking is enabled, a 32-bit mask word holds four rows of four 2-bit lane operations. The output vector index, reduced modulo the write length and clamped to 3, selects the row. Each lane then chooses between the (possibly summed) input, its own row register, the column value picked by the selected mask row, or the old memory contents (write inhibit). The result is registered, so it appears one cycle after the vector is presented. The row registers can be loaded from outside.

Top module: `rcw_merge`

## Requirements
- R1: With mode 1 (add-row), every output lane equals the input lane plus the row register of the same lane, wrapping modulo 2^LANE_W, and the row registers do not change.
- R2: With mode 0 (input) or mode 3 (undefined), input lanes pass to the output unchanged and the row registers do not change.
- R3: The mask row used for a vector is min(vec_idx % wr_len, 3). A wr_len of 0 stands for 2^WL_W.
- R4: With mask_en high, lane l of mask row r is the operation in mask_word bits [8r+2l+1 : 8r+2l]: 0 takes the input (summed in modes 1 and 2), 1 takes row register l, 2 takes column value r (col_vals bits [32r+31:32r]), 3 keeps old_data lane l. Lane l sits in bits [32l+31:32l] of every quadword port.
- R5: In mode 2 (accumulate-row) with mask_en high, only lanes whose operation is 0 write their summed value into their row register. The other row registers keep their values.
- R6: In mode 2 with mask_en low, the output is the full summed quadword and all four row registers take the summed lanes.
- R7: A row register update made by one vector is seen by a vector presented in the very next cycle.
- R8: out_valid is high exactly one cycle after a cycle with vec_valid high. out_data holds its value through cycles without a vector.
- R9: row_load writes row_load_data into all row registers at the next edge and takes priority over accumulate write-back in the same cycle. A vector in that cycle is computed with the row values held before the load.
- R10: After reset, out_valid is low and out_data and all row registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_valid | input | 1 | A vector is presented this cycle |
| mode | input | 2 | 0 input, 1 add-row, 2 accumulate-row, 3 treated as input |
| mask_en | input | 1 | Apply per-lane mask operations |
| vec_idx | input | IDX_W | Output vector index within the transfer |
| wr_len | input | WL_W | Write length; 0 means 2^WL_W |
| mask_word | input | 32 | Four rows of four 2-bit lane operations |
| col_vals | input | 4*LANE_W | Four column values |
| in_data | input | 4*LANE_W | Unpacked input quadword |
| old_data | input | 4*LANE_W | Current memory contents at the destination |
| row_load | input | 1 | Load the row registers |
| row_load_data | input | 4*LANE_W | Values for a row load |
| out_valid | output | 1 | out_data holds a new result |
| out_data | output | 4*LANE_W | Quadword to write back |
| row_vals | output | 4*LANE_W | Current row registers |

## Verification
A wrong mask row index or lane operation shows as a wrong lane in out_data one cycle after the vector, most clearly when the candidate sources differ lane by lane. A corrupted row register may stay hidden while the mode is 0. It surfaces on row_vals at the next edge and in out_data on the first later vector that adds rows or selects a row lane. For that reason the stimulus runs accumulate and add-row vectors back to back with distinct row, column and old values.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

    localparam int LANES     = 4;
    localparam int MASK_ROWS = 4;
    localparam int OP_W      = 2;
    localparam int MASK_W    = MASK_ROWS * LANES * OP_W;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_ADDROW = 2'd1,
        MODE_ACCROW = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_INPUT = 2'd0,
        OP_ROW   = 2'd1,
        OP_COL   = 2'd2,
        OP_KEEP  = 2'd3
    } lane_op_e;

endpackage

// File: rtl/rcw_mask_row.sv
module rcw_mask_row #(
    parameter int IDX_W = 10,
    parameter int WL_W  = 8
) (
    input  logic [IDX_W-1:0] vec_idx,
    input  logic [WL_W-1:0]  wr_len,
    output logic [1:0]       row_sel
);
    localparam int DW = (IDX_W > WL_W + 1) ? IDX_W : WL_W + 1;

    logic [DW-1:0] divisor;
    logic [DW-1:0] rem;

    always_comb begin
        if (wr_len == '0) begin
            divisor = DW'(1) << WL_W;
        end else begin
            divisor = DW'(wr_len);
        end
        rem = DW'(vec_idx) % divisor;
        if (rem > DW'(3)) begin
            row_sel = 2'd3;
        end else begin
            row_sel = rem[1:0];
        end
    end
endmodule

// File: rtl/rcw_lane.sv
module rcw_lane
    import rcw_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  mode_e              mode,
    input  logic               mask_en,
    input  lane_op_e           op,
    input  logic [LANE_W-1:0]  in_v,
    input  logic [LANE_W-1:0]  old_v,
    input  logic [LANE_W-1:0]  row_v,
    input  logic [LANE_W-1:0]  col_v,
    output logic [LANE_W-1:0]  out_v,
    output logic               wb_en,
    output logic [LANE_W-1:0]  wb_v
);
    logic [LANE_W-1:0] sum_v;
    logic              adds_row;
    logic              accum;

    always_comb begin
        adds_row = (mode == MODE_ADDROW) || (mode == MODE_ACCROW);
        accum    = (mode == MODE_ACCROW);
        sum_v    = adds_row ? (in_v + row_v) : in_v;
        wb_v     = sum_v;
        out_v    = sum_v;
        wb_en    = 1'b0;
        if (!mask_en) begin
            wb_en = accum;
        end else begin
            unique case (op)
                OP_INPUT: begin
                    out_v = sum_v;
                    wb_en = accum;
                end
                OP_ROW:  out_v = row_v;
                OP_COL:  out_v = col_v;
                OP_KEEP: out_v = old_v;
                default: out_v = sum_v;
            endcase
        end
    end
endmodule

// File: rtl/rcw_merge.sv
module rcw_merge
    import rcw_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int IDX_W  = 10,
    parameter int WL_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vec_valid,
    input  logic [1:0]               mode,
    input  logic                     mask_en,
    input  logic [IDX_W-1:0]         vec_idx,
    input  logic [WL_W-1:0]          wr_len,
    input  logic [MASK_W-1:0]        mask_word,
    input  logic [LANES*LANE_W-1:0]  col_vals,
    input  logic [LANES*LANE_W-1:0]  in_data,
    input  logic [LANES*LANE_W-1:0]  old_data,
    input  logic                     row_load,
    input  logic [LANES*LANE_W-1:0]  row_load_data,
    output logic                     out_valid,
    output logic [LANES*LANE_W-1:0]  out_data,
    output logic [LANES*LANE_W-1:0]  row_vals
);
    localparam int QW     = LANES * LANE_W;
    localparam int ROW_OP = LANES * OP_W;

    typedef struct packed {
        logic          vld;
        logic [QW-1:0] out;
        logic [QW-1:0] row;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]        row_sel;
    logic [LANES-1:0]  wb_en;
    logic [QW-1:0]     lane_out;
    logic [QW-1:0]     lane_wb;
    logic [LANE_W-1:0] col_pick;
    mode_e             mode_v;

    assign mode_v   = mode_e'(mode);
    assign col_pick = col_vals[row_sel*LANE_W +: LANE_W];

    rcw_mask_row #(
        .IDX_W (IDX_W),
        .WL_W  (WL_W)
    ) u_mask_row (
        .vec_idx (vec_idx),
        .wr_len  (wr_len),
        .row_sel (row_sel)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [OP_W-1:0] op_bits;
        assign op_bits = mask_word[row_sel*ROW_OP + g*OP_W +: OP_W];

        rcw_lane #(
            .LANE_W (LANE_W)
        ) u_lane (
            .mode    (mode_v),
            .mask_en (mask_en),
            .op      (lane_op_e'(op_bits)),
            .in_v    (in_data[g*LANE_W +: LANE_W]),
            .old_v   (old_data[g*LANE_W +: LANE_W]),
            .row_v   (st_q.row[g*LANE_W +: LANE_W]),
            .col_v   (col_pick),
            .out_v   (lane_out[g*LANE_W +: LANE_W]),
            .wb_en   (wb_en[g]),
            .wb_v    (lane_wb[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vec_valid;
        if (vec_valid) begin
            st_d.out = lane_out;
            for (int l = 0; l < LANES; l++) begin
                if (wb_en[l]) begin
                    st_d.row[l*LANE_W +: LANE_W] = lane_wb[l*LANE_W +: LANE_W];
                end
            end
        end
        if (row_load) begin
            st_d.row = row_load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.out;
    assign row_vals  = st_q.row;
endmodule

// File: rtl/rcw_merge_chk.sv
module rcw_merge_chk
    import rcw_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int IDX_W  = 10,
    parameter int WL_W   = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     vec_valid,
    input logic [1:0]               mode,
    input logic                     mask_en,
    input logic [MASK_W-1:0]        mask_word,
    input logic [LANES*LANE_W-1:0]  in_data,
    input logic [LANES*LANE_W-1:0]  old_data,
    input logic                     row_load,
    input logic                     out_valid,
    input logic [LANES*LANE_W-1:0]  out_data,
    input logic [LANES*LANE_W-1:0]  row_vals
);
    // R8: output valid tracks the presented vector one cycle later
    a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> out_valid);
    a_r8_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |=> !out_valid);
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |=> $stable(out_data));

    // R2: pass-through modes leave data and rows untouched
    a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !mask_en && (mode == 2'd0 || mode == 2'd3))
        |=> out_data == $past(in_data));
    a_r2_rows_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_load && (!vec_valid || mode == 2'd0 || mode == 2'd3))
        |=> $stable(row_vals));

    // R1: add-row never writes the rows
    a_r1_rows_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && mode == 2'd1 && !row_load) |=> $stable(row_vals));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R1: per-lane sum with the row register
        a_r1_add_lane: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_valid && !mask_en && mode == 2'd1)
            |=> out_data[g*LANE_W +: LANE_W] ==
                $past(in_data[g*LANE_W +: LANE_W]) + $past(row_vals[g*LANE_W +: LANE_W]));
    end

    // R4: an all-keep mask reproduces the old quadword
    a_r4_keep_all: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && mask_en && mask_word == '1) |=> out_data == $past(old_data));

    // R5: no input lanes selected means no accumulation
    a_r5_no_input_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && mask_en && mask_word == '1 && !row_load) |=> $stable(row_vals));

    // R6: unmasked accumulate stores the same sums it outputs
    a_r6_acc_rows_match: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !mask_en && mode == 2'd2 && !row_load) |=> row_vals == out_data);
endmodule

bind rcw_merge rcw_merge_chk #(
    .LANE_W (LANE_W),
    .IDX_W  (IDX_W),
    .WL_W   (WL_W)
) u_rcw_merge_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_valid (vec_valid),
    .mode      (mode),
    .mask_en   (mask_en),
    .mask_word (mask_word),
    .in_data   (in_data),
    .old_data  (old_data),
    .row_load  (row_load),
    .out_valid (out_valid),
    .out_data  (out_data),
    .row_vals  (row_vals)
);

// File: tb/test_rcw_merge.sv
module test_rcw_merge;
    localparam int W  = 32;
    localparam int QW = 4 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vec_valid = 1'b0;
    logic [1:0]    mode = '0;
    logic          mask_en = 1'b0;
    logic [9:0]    vec_idx = '0;
    logic [7:0]    wr_len = 8'd1;
    logic [31:0]   mask_word = '0;
    logic [QW-1:0] col_vals = '0;
    logic [QW-1:0] in_data = '0;
    logic [QW-1:0] old_data = '0;
    logic          row_load = 1'b0;
    logic [QW-1:0] row_load_data = '0;
    logic          out_valid;
    logic [QW-1:0] out_data;
    logic [QW-1:0] row_vals;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [QW-1:0] m_rows = '0;
    logic [QW-1:0] m_out  = '0;

    always #5 clk = ~clk;

    rcw_merge i_rcw_merge (
        .clk           (clk),
        .rst_n         (rst_n),
        .vec_valid     (vec_valid),
        .mode          (mode),
        .mask_en       (mask_en),
        .vec_idx       (vec_idx),
        .wr_len        (wr_len),
        .mask_word     (mask_word),
        .col_vals      (col_vals),
        .in_data       (in_data),
        .old_data      (old_data),
        .row_load      (row_load),
        .row_load_data (row_load_data),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .row_vals      (row_vals)
    );

    function automatic int mask_row_of(input logic [9:0] idx, input logic [7:0] wl);
        int d = (wl == 0) ? 256 : int'(wl);
        int r = int'(idx) % d;
        return (r > 3) ? 3 : r;
    endfunction

    task automatic check(input string tag, input logic [QW-1:0] act, input logic [QW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compute expected results from the driven inputs, clock once, compare.
    task automatic step(input string tag);
        logic [QW-1:0] e_out  = m_out;
        logic [QW-1:0] e_rows = m_rows;
        logic          e_vld  = vec_valid;
        int            sel    = mask_row_of(vec_idx, wr_len);
        if (vec_valid) begin
            for (int l = 0; l < 4; l++) begin
                logic [W-1:0] s = in_data[l*W +: W];
                logic [W-1:0] o;
                logic         wb = 1'b0;
                if (mode == 2'd1 || mode == 2'd2) s = s + m_rows[l*W +: W];
                o = s;
                if (!mask_en) begin
                    wb = (mode == 2'd2);
                end else begin
                    case (mask_word[sel*8 + l*2 +: 2])
                        2'd0: begin o = s; wb = (mode == 2'd2); end
                        2'd1: o = m_rows[l*W +: W];
                        2'd2: o = col_vals[sel*W +: W];
                        default: o = old_data[l*W +: W];
                    endcase
                end
                e_out[l*W +: W] = o;
                if (wb) e_rows[l*W +: W] = s;
            end
        end
        if (row_load) e_rows = row_load_data;
        @(negedge clk);
        check({tag, " valid"}, {127'd0, out_valid}, {127'd0, e_vld});
        check({tag, " data"}, out_data, e_out);
        check({tag, " rows"}, row_vals, e_rows);
        m_out  = e_out;
        m_rows = e_rows;
    endtask

    function automatic logic [QW-1:0] rq();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid", {127'd0, out_valid}, 128'd0);
        check("R10 data", out_data, '0);
        check("R10 rows", row_vals, '0);
        rst_n = 1'b1;

        // R9: plain row load
        row_load = 1'b1;
        row_load_data = {32'd4, 32'd3, 32'd2, 32'd1};
        step("R9 load");
        row_load = 1'b0;

        // R1: add-row with wraparound in lane 0
        vec_valid = 1'b1; mode = 2'd1; mask_en = 1'b0;
        in_data = {32'd100, 32'd200, 32'd300, 32'hFFFF_FFFF};
        step("R1 add wrap");

        // R2: undefined mode passes input through
        mode = 2'd3; in_data = rq();
        step("R2 mode3");
        mode = 2'd0; in_data = rq();
        step("R2 mode0");

        // R6 / R7: back-to-back unmasked accumulation
        mode = 2'd2; in_data = {32'd10, 32'd20, 32'd30, 32'd40};
        step("R6 acc first");
        step("R7 acc second");

        // R8: idle cycles hold the output
        vec_valid = 1'b0; in_data = rq();
        step("R8 idle");
        step("R8 idle2");
        vec_valid = 1'b1;

        // R3: write length 0 means 256; 255 -> row 3, 256 -> row 0
        mode = 2'd0; mask_en = 1'b1;
        mask_word = {8'b10_10_10_10, 8'b01_01_01_01, 8'b11_11_11_11, 8'b00_00_00_00};
        col_vals = rq(); old_data = rq(); in_data = rq();
        wr_len = 8'd0; vec_idx = 10'd255;
        step("R3 wl0 idx255");
        vec_idx = 10'd256;
        step("R3 wl0 idx256");
        wr_len = 8'd5; vec_idx = 10'd7;
        step("R3 wl5 idx7");
        wr_len = 8'd1; vec_idx = 10'd3;
        step("R3 wl1");

        // R4: every lane takes a different source
        wr_len = 8'd8; vec_idx = 10'd2;
        mask_word = 32'h0;
        mask_word[23:16] = 8'b11_10_01_00;
        old_data = rq(); col_vals = rq(); in_data = rq();
        step("R4 mixed ops");

        // R5: accumulate with mask, only input lanes write back
        mode = 2'd2;
        mask_word[23:16] = 8'b00_01_00_11;
        in_data = rq();
        step("R5 acc masked");
        step("R7 acc masked next");

        // R9: load wins over accumulate; vector uses old rows
        mask_en = 1'b0; row_load = 1'b1; row_load_data = rq(); in_data = rq();
        step("R9 load vs acc");
        row_load = 1'b0;

        // random mix, all requirements
        for (int k = 0; k < 400; k++) begin
            vec_valid     = ($urandom_range(0, 7) != 0);
            mode          = 2'($urandom_range(0, 3));
            mask_en       = 1'($urandom_range(0, 1));
            vec_idx       = 10'($urandom_range(0, 1023));
            wr_len        = ($urandom_range(0, 9) == 0) ? 8'd0 : 8'($urandom_range(1, 7));
            mask_word     = $urandom();
            col_vals      = rq();
            in_data       = rq();
            old_data      = rq();
            row_load      = ($urandom_range(0, 15) == 0);
            row_load_data = rq();
            step("R4 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule